// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns an integer held in a 64-bit word into an IEEE 754 binary floating-point value. A 2-bit type code selects one of four integer sources: signed or unsigned, 32 or 64 bits wide. A precision select chooses the destination format. A double-precision result is delivered directly. A single-precision result is rounded to single range and precision and then widened exactly into the 64-bit double encoding, so the output word always has the double layout.

Where the conversion can lose bits, the value is rounded according to a 2-bit rounding-mode input. The unit also reports four pieces of status:
- a class code for the rounded value;
- an inexact flag;
- a flag saying the significand was rounded up;
- a write enable for the status flags.

The write enable is low only for the conversions that can never round, which are 32-bit sources converted to double.

The result and all status signals are registered, and they appear one clock after the inputs are applied. There is no handshake: the unit accepts a new conversion every cycle.

Top module: `i2f_conv`

## Requirements
- R1: `src_type` selects the source: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. The 32-bit types use only `src_word[31:0]`, and the upper half of the word has no effect on the result.
- R2: `flag_wr_en` is 0 when a 32-bit type is converted to double (`to_single`=0, `src_type`<2). It is 1 for every other conversion.
- R3: A 32-bit source converted to double is exact in every rounding mode, so `inexact` and `frac_inc` are both 0.
- R4: 64-bit sources converted to double, and any source converted to single, are rounded according to `rnd_mode`. The encodings are 00 round to nearest with ties to even, 01 round toward zero, 10 round toward +infinity and 11 round toward -infinity.
- R5: With `to_single`=1 the value is rounded to 24 significand bits and then encoded as a double. As a result, `res_bits[28:0]` is always 0.
- R6: `res_class` classifies the rounded value. The codes are 5'b00100 for a positive normal, 5'b01000 for a negative normal and 5'b00010 for positive zero.
- R7: `inexact` is 1 exactly when rounding discards non-zero bits.
- R8: `frac_inc` is 1 exactly when the significand is rounded up in magnitude, and it implies `inexact`.
- R9: The most negative signed 64-bit value converts exactly to -2^63, which is 64'hC3E0000000000000 in double encoding.
- R10: An integer zero of any type converts to +0.0 (all bits 0) with class positive zero in every rounding mode.
- R11: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_word | input | 64 | Integer operand |
| src_type | input | 2 | Integer source type code |
| to_single | input | 1 | 1: round to single, output in double layout |
| rnd_mode | input | 2 | Rounding mode |
| res_bits | output | 64 | Floating-point result, double encoding |
| res_class | output | 5 | Class code of the rounded result |
| inexact | output | 1 | Bits lost in rounding |
| frac_inc | output | 1 | Significand rounded up |
| flag_wr_en | output | 1 | Status flags should be written |

## Verification
The directed inputs are zero, ±1, 2^24±1, 2^53±1, the all-ones unsigned value and the most negative signed value. Each is applied in every rounding mode, every type and both precisions.
- 2^24+1 and 2^53+1 sit exactly halfway between two neighbours in single and double. They separate the four rounding modes and show whether ties go to even.
- 2^24-1 and 2^53-1 must stay exact, which catches an off-by-one in the guard position.
- All-ones and the most negative value exercise the carry out of rounding into the exponent and the negation of the largest magnitude.

Random words are also applied, right-shifted by random amounts so that every leading-one position occurs. They are checked against a bench model that rounds by comparing the remainder against one half, rather than using guard and sticky bits.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int WORD_W   = 64;
  localparam int DBL_EXP  = 11;
  localparam int DBL_FRAC = 52;
  localparam int DBL_BIAS = 1023;
  localparam int DBL_PREC = DBL_FRAC + 1;
  localparam int SGL_PREC = 24;
  localparam int IDX_W    = $clog2(WORD_W);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rnd_mode_e;

  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
endpackage

// File: rtl/i2f_signmag.sv
module i2f_signmag #(
  parameter int W = 64
) (
  input  logic [W-1:0] word,
  input  logic [1:0]   src_type,
  output logic         neg,
  output logic [W-1:0] mag
);
  localparam int HW = W / 2;

  logic [W-1:0] ext;

  always_comb begin
    // bit 1 of the type picks the width, bit 0 picks unsigned
    if (src_type[1]) begin
      ext = word;
      neg = ~src_type[0] & word[W-1];
    end else begin
      neg = ~src_type[0] & word[HW-1];
      ext = {{HW{neg}}, word[HW-1:0]};
    end
    mag = neg ? (~ext + W'(1)) : ext;
  end
endmodule

// File: rtl/i2f_norm.sv
module i2f_norm #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  mag,
  output logic          is_zero,
  output logic [IW-1:0] lead_idx,
  output logic [W-1:0]  norm
);
  always_comb begin
    lead_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (mag[i]) lead_idx = IW'(i);
    end
    is_zero = (mag == '0);
    norm    = mag << (IW'(W - 1) - lead_idx);
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int W = 64,
  parameter int P = 53
) (
  input  logic [W-1:0] norm,
  input  logic         neg,
  input  logic [1:0]   mode,
  output logic [P-1:0] mant,
  output logic         carry,
  output logic         inexact,
  output logic         inc
);
  logic [P-1:0] keep;
  logic         guard;
  logic         sticky;
  logic [P:0]   sum;

  always_comb begin
    keep    = norm[W-1 -: P];
    guard   = norm[W-1-P];
    sticky  = |norm[W-2-P:0];
    inexact = guard | sticky;
    unique case (rnd_mode_e'(mode))
      RM_NEAR: inc = guard & (sticky | keep[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = inexact & ~neg;
      RM_DOWN: inc = inexact & neg;
      default: inc = 1'b0;
    endcase
    sum   = {1'b0, keep} + {{P{1'b0}}, inc};
    carry = sum[P];
    mant  = carry ? sum[P:1] : sum[P-1:0];
  end
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
  import i2f_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_word,
  input  logic [1:0]  src_type,
  input  logic        to_single,
  input  logic [1:0]  rnd_mode,
  output logic [63:0] res_bits,
  output logic [4:0]  res_class,
  output logic        inexact,
  output logic        frac_inc,
  output logic        flag_wr_en
);
  localparam int PAD_S = DBL_FRAC - (SGL_PREC - 1);

  logic                neg;
  logic [WORD_W-1:0]   mag;
  logic                is_zero;
  logic [IDX_W-1:0]    lead_idx;
  logic [WORD_W-1:0]   norm;
  logic [DBL_PREC-1:0] mant_d;
  logic [SGL_PREC-1:0] mant_s;
  logic                carry_d, carry_s, inx_d, inx_s, inc_d, inc_s;

  i2f_signmag #(.W(WORD_W)) u_sm (
    .word(src_word), .src_type(src_type), .neg(neg), .mag(mag)
  );

  i2f_norm #(.W(WORD_W), .IW(IDX_W)) u_norm (
    .mag(mag), .is_zero(is_zero), .lead_idx(lead_idx), .norm(norm)
  );

  i2f_round #(.W(WORD_W), .P(DBL_PREC)) u_rnd_d (
    .norm(norm), .neg(neg), .mode(rnd_mode), .mant(mant_d),
    .carry(carry_d), .inexact(inx_d), .inc(inc_d)
  );

  i2f_round #(.W(WORD_W), .P(SGL_PREC)) u_rnd_s (
    .norm(norm), .neg(neg), .mode(rnd_mode), .mant(mant_s),
    .carry(carry_s), .inexact(inx_s), .inc(inc_s)
  );

  logic [63:0]        bits_nx;
  logic [4:0]         cls_nx;
  logic               inx_nx, inc_nx, wen_nx;
  logic               carry_sel;
  logic [IDX_W:0]     exp_unb;
  logic [DBL_EXP-1:0] exp_enc;
  logic [DBL_FRAC-1:0] frac_sel;

  always_comb begin
    carry_sel = to_single ? carry_s : carry_d;
    exp_unb   = {1'b0, lead_idx} + {{IDX_W{1'b0}}, carry_sel};
    exp_enc   = DBL_EXP'(exp_unb) + DBL_EXP'(DBL_BIAS);
    frac_sel  = to_single ? {mant_s[SGL_PREC-2:0], {PAD_S{1'b0}}}
                          : mant_d[DBL_PREC-2:0];
    if (is_zero) begin
      bits_nx = '0;
      cls_nx  = CLS_POS_ZERO;
      inx_nx  = 1'b0;
      inc_nx  = 1'b0;
    end else begin
      bits_nx = {neg, exp_enc, frac_sel};
      cls_nx  = neg ? CLS_NEG_NORM : CLS_POS_NORM;
      inx_nx  = to_single ? inx_s : inx_d;
      inc_nx  = to_single ? inc_s : inc_d;
    end
    wen_nx = to_single | src_type[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_bits   <= '0;
      res_class  <= '0;
      inexact    <= 1'b0;
      frac_inc   <= 1'b0;
      flag_wr_en <= 1'b0;
    end else begin
      res_bits   <= bits_nx;
      res_class  <= cls_nx;
      inexact    <= inx_nx;
      frac_inc   <= inc_nx;
      flag_wr_en <= wen_nx;
    end
  end
endmodule

// File: rtl/i2f_conv_chk.sv
module i2f_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_word,
  input logic [1:0]  src_type,
  input logic        to_single,
  input logic [63:0] res_bits,
  input logic [4:0]  res_class,
  input logic        inexact,
  input logic        frac_inc,
  input logic        flag_wr_en
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r2_no_flag_write: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(!to_single && !src_type[1]) |-> !flag_wr_en);

  a_r3_exact_narrow: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(!to_single && !src_type[1]) |-> (!inexact && !frac_inc));

  a_r5_single_tail_zero: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(to_single) |-> (res_bits[28:0] == 29'd0));

  a_r6_class_single_code: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $countones(res_class) == 1);

  a_r8_inc_needs_inexact: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    frac_inc |-> inexact);

  a_r10_zero_result: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(src_word == 64'd0) |-> (res_bits == 64'd0 && !inexact));
endmodule

bind i2f_conv i2f_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_word(src_word), .src_type(src_type),
  .to_single(to_single), .res_bits(res_bits), .res_class(res_class),
  .inexact(inexact), .frac_inc(frac_inc), .flag_wr_en(flag_wr_en)
);

// File: tb/i2f_conv_bench.sv
module i2f_conv_bench;
  logic        clk;
  logic        rst_n;
  logic [63:0] src_word;
  logic [1:0]  src_type;
  logic        to_single;
  logic [1:0]  rnd_mode;
  logic [63:0] res_bits;
  logic [4:0]  res_class;
  logic        inexact, frac_inc, flag_wr_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  i2f_conv u_i2f_conv (
    .clk(clk), .rst_n(rst_n), .src_word(src_word), .src_type(src_type),
    .to_single(to_single), .rnd_mode(rnd_mode), .res_bits(res_bits),
    .res_class(res_class), .inexact(inexact), .frac_inc(frac_inc),
    .flag_wr_en(flag_wr_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s word=%h type=%0d sgl=%0b mode=%0d act=%h exp=%h",
               req, src_word, src_type, to_single, rnd_mode, act, exp);
    end
  endtask

  // Reference: rounding decided by comparing the discarded remainder with one half
  function automatic void ref_cvt(input logic [63:0] w, input logic [1:0] t,
                                  input logic sgl, input logic [1:0] m,
                                  output logic [63:0] bits, output logic [4:0] cls,
                                  output logic inx, output logic inc);
    logic        neg;
    logic [63:0] mag, rem, half, frac;
    logic [64:0] mant;
    int e, p, sh;
    if (t[1] == 1'b0) begin
      neg = (t == 2'd0) && w[31];
      mag = neg ? (~{32'hFFFF_FFFF, w[31:0]} + 64'd1) : {32'd0, w[31:0]};
    end else begin
      neg = (t == 2'd2) && w[63];
      mag = neg ? (~w + 64'd1) : w;
    end
    inx = 1'b0; inc = 1'b0;
    if (mag == 64'd0) begin
      bits = 64'd0; cls = 5'b00010;
      return;
    end
    e = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) e = i;
    p = sgl ? 24 : 53;
    if (e < p) begin
      mant = 65'(mag) << (p - 1 - e);
    end else begin
      sh   = e - p + 1;
      mant = 65'(mag >> sh);
      rem  = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      inx  = (rem != 64'd0);
      case (m)
        2'd0: inc = (rem > half) || (rem == half && mant[0]);
        2'd1: inc = 1'b0;
        2'd2: inc = inx && !neg;
        default: inc = inx && neg;
      endcase
      mant = mant + 65'(inc);
      if (mant == (65'd1 << p)) begin
        mant = mant >> 1;
        e++;
      end
    end
    frac = (mant[63:0] & ((64'd1 << (p - 1)) - 64'd1)) << (53 - p);
    bits = {neg, 11'(e + 1023), frac[51:0]};
    cls  = neg ? 5'b01000 : 5'b00100;
  endfunction

  task automatic apply_and_check(input logic [63:0] w, input logic [1:0] t,
                                 input logic sgl, input logic [1:0] m);
    logic [63:0] eb; logic [4:0] ec; logic ei, ef;
    @(negedge clk);
    src_word = w; src_type = t; to_single = sgl; rnd_mode = m;
    ref_cvt(w, t, sgl, m, eb, ec, ei, ef);
    @(negedge clk);
    // R11: result visible one edge after the inputs
    check(sgl ? "R5 R4 result" : (t[1] ? "R4 result" : "R1 R3 result"), res_bits, eb);
    check("R6 class", 64'(res_class), 64'(ec));
    check("R7 inexact", 64'(inexact), 64'(ei));
    check("R8 frac_inc", 64'(frac_inc), 64'(ef));
    check("R2 flag_wr_en", 64'(flag_wr_en), 64'(sgl | t[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] corners [12];
    int unused_seed;
    corners[0]  = 64'd0;
    corners[1]  = 64'd1;
    corners[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[3]  = 64'd16777215;
    corners[4]  = 64'd16777217;
    corners[5]  = 64'h001F_FFFF_FFFF_FFFF;
    corners[6]  = 64'h0020_0000_0000_0001;
    corners[7]  = 64'h8000_0000_0000_0000;
    corners[8]  = 64'hFFFF_FFFF_FEFF_FFFF;
    corners[9]  = 64'hFFFF_FFFF_8000_0000;
    corners[10] = 64'hFFDF_FFFF_FFFF_FFFF;
    corners[11] = 64'h1234_5678_0000_0000;

    unused_seed = $urandom(32'd20240611);
    rst_n = 1'b0; src_word = '0; src_type = '0; to_single = 1'b0; rnd_mode = '0;
    repeat (3) @(negedge clk);
    // R11: outputs held at zero during reset
    check("R11 reset res_bits", res_bits, 64'd0);
    check("R11 reset flags", {54'd0, res_class, inexact, frac_inc, flag_wr_en}, 64'd0);
    rst_n = 1'b1;

    // R9: exact most negative signed 64
    apply_and_check(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd0);
    check("R9 min signed", res_bits, 64'hC3E0_0000_0000_0000);
    // R10: zero in toward -inf mode stays +0
    apply_and_check(64'd0, 2'd2, 1'b1, 2'd3);
    check("R10 zero", res_bits, 64'd0);
    // R4: tie above 2^53 under nearest-even and toward +inf
    apply_and_check(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd0);
    check("R4 nearest tie", res_bits, 64'h4340_0000_0000_0000);
    apply_and_check(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd2);
    check("R4 up tie", res_bits, 64'h4340_0000_0000_0001);
    // R5: 2^24+1 to single rounds to 2^24
    apply_and_check(64'd16777217, 2'd1, 1'b1, 2'd0);
    check("R5 single tie", res_bits, 64'h4170_0000_0000_0000);
    // R8: all-ones unsigned rounds up to 2^64
    apply_and_check(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd0);
    check("R8 carry to 2^64", res_bits, 64'h43F0_0000_0000_0000);
    // R1 R3: -1 as signed 32 to double, upper half ignored
    apply_and_check(64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0, 2'd1);
    check("R1 neg one", res_bits, 64'hBFF0_0000_0000_0000);
    apply_and_check(64'hABCD_0000_FFFF_FFFF, 2'd0, 1'b0, 2'd1);
    check("R1 upper ignored", res_bits, 64'hBFF0_0000_0000_0000);

    for (int c = 0; c < 12; c++)
      for (int t = 0; t < 4; t++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 4; m++)
            apply_and_check(corners[c], 2'(t), 1'(s), 2'(m));

    for (int n = 0; n < 1500; n++) begin
      logic [63:0] w;
      w = {$urandom(), $urandom()} >> ($urandom() % 64);
      apply_and_check(w, 2'($urandom()), 1'($urandom()), 2'($urandom()));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule